// File: doc/BRIEF.md
# Bit-Serial Column SIMD Array

A digital model of a storage subarray whose columns double as one-bit processing lanes. Each element of a vector occupies one column, stored transposed: bit k of the value sits in row base+k. A command names an operation, two source base rows, a destination base row and an operand width. The engine then visits the operand bits from least to most significant. In each step it reads the two source rows, combines them bit by bit across all columns at once, and writes one destination row. A carry latch per column passes state from one step to the next.

All columns run the same command in parallel, so throughput scales with the column count and latency scales with the operand width. Bitwise AND, NOR and copy write one row per step. Add, subtract and unsigned greater-than are built from the same per-step adder. While no command runs, a plain row write port and a row read port give direct access to the array.

Top module: `bs_simd_array`

## Requirements
- R1: After reset, busy_o is low and every row reads as all zeros.
- R2: While idle, wr_en_i stores wr_data_i into row wr_addr_i at the clock edge. rd_data_o shows row rd_addr_i combinationally. Host writes presented while busy_o is high are dropped.
- R3: Opcodes are 0 AND, 1 NOR, 2 copy. For each i below the width n, destination row d+i gets A(a+i) AND B(b+i), NOR of the two, or A(a+i), per column.
- R4: Opcode 3 (add) writes the n low sum bits of A+B to rows d..d+n-1 and the final carry to row d+n, per column.
- R5: Opcode 4 (subtract) writes (A-B) mod 2^n to rows d..d+n-1. It adds the inverted B with each column's carry preset to 1.
- R6: Opcode 5 (compare) writes only row d, whose bit is 1 in each column where unsigned A > B. This is the final carry of A + ~B with the carry preset to 0.
- R7: A command is accepted when cmd_valid_i is high, busy_o is low and the opcode is legal. busy_o rises at the accept edge and stays high for 1+n cycles (AND, NOR, copy, subtract) or 2+n cycles (add, compare).
- R8: A command presented while busy_o is high is not accepted and has no effect.
- R9: Opcodes 6 and 7 are never accepted: busy_o stays low and no row changes.
- R10: A width field of 0 selects the default width of 8. A width above MAX_WIDTH (16) is clamped to MAX_WIDTH.
- R11: Row addresses base+i wrap modulo the row count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_op_i | input | 3 | Opcode |
| cmd_src_a_i | input | 6 | Base row of operand A |
| cmd_src_b_i | input | 6 | Base row of operand B |
| cmd_dst_i | input | 6 | Base row of the result |
| cmd_width_i | input | 5 | Operand width, 0 selects the default |
| busy_o | output | 1 | Command in progress |
| wr_en_i | input | 1 | Host row write enable |
| wr_addr_i | input | 6 | Host write row |
| wr_data_i | input | 64 | Host write data |
| rd_addr_i | input | 6 | Host read row |
| rd_data_o | output | 64 | Host read data |

## Verification
The assertions check on every cycle the length of each busy window against the accepted opcode and width, that illegal or busy-time commands never start a run, that the engine writes only inside a run, and that the carry latch holds its preset when the first bit step starts. The arithmetic contents of the result rows, the carry row of an add, the single compare row, default and clamped widths, and address wrap-around are only shown by the bench's scenarios. In those, a behavioural model of the whole array is compared with the read port and the busy flag.

// File: rtl/bs_simd_pkg.sv
package bs_simd_pkg;
  typedef enum logic [2:0] {
    OP_AND   = 3'd0,
    OP_NOR   = 3'd1,
    OP_COPY  = 3'd2,
    OP_ADD   = 3'd3,
    OP_SUB   = 3'd4,
    OP_CMPGT = 3'd5
  } op_e;

  function automatic logic op_legal(logic [2:0] code);
    return code <= 3'd5;
  endfunction

  // ops that spend one extra step emitting the carry row
  function automatic logic op_has_tail(op_e op);
    return (op == OP_ADD) || (op == OP_CMPGT);
  endfunction

  function automatic logic op_inv_b(op_e op);
    return (op == OP_SUB) || (op == OP_CMPGT);
  endfunction
endpackage

// File: rtl/bs_simd_mem.sv
module bs_simd_mem #(
  parameter int NUM_COLS = 64,
  parameter int NUM_ROWS = 64,
  localparam int RAW = $clog2(NUM_ROWS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [RAW-1:0]      waddr_i,
  input  logic [NUM_COLS-1:0] wdata_i,
  input  logic [RAW-1:0]      raddr_a_i,
  input  logic [RAW-1:0]      raddr_b_i,
  input  logic [RAW-1:0]      raddr_h_i,
  output logic [NUM_COLS-1:0] rdata_a_o,
  output logic [NUM_COLS-1:0] rdata_b_o,
  output logic [NUM_COLS-1:0] rdata_h_o
);
  logic [NUM_COLS-1:0] mem_q [NUM_ROWS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_ROWS; r++) mem_q[r] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
  assign rdata_h_o = mem_q[raddr_h_i];
endmodule

// File: rtl/bs_simd_lanes.sv
module bs_simd_lanes
  import bs_simd_pkg::*;
#(
  parameter int NUM_COLS = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  op_e                 op_i,
  input  logic [NUM_COLS-1:0] a_row_i,
  input  logic [NUM_COLS-1:0] b_row_i,
  input  logic                tail_i,
  input  logic                preset_i,
  input  logic                step_i,
  output logic [NUM_COLS-1:0] res_row_o,
  output logic [NUM_COLS-1:0] carry_o
);
  logic [NUM_COLS-1:0] carry_q, bx, sum_w, cout_w, res_w;

  assign bx = op_inv_b(op_i) ? ~b_row_i : b_row_i;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_lane
    logic prop;
    assign prop      = a_row_i[c] ^ bx[c];
    assign sum_w[c]  = prop ^ carry_q[c];
    assign cout_w[c] = (a_row_i[c] & bx[c]) | (carry_q[c] & prop);
    assign res_w[c]  = (op_i == OP_AND)  ? (a_row_i[c] & b_row_i[c]) :
                       (op_i == OP_NOR)  ? ~(a_row_i[c] | b_row_i[c]) :
                       (op_i == OP_COPY) ? a_row_i[c] :
                       tail_i            ? carry_q[c] : sum_w[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       carry_q <= '0;
    else if (preset_i) carry_q <= (op_i == OP_SUB) ? '1 : '0;
    else if (step_i)   carry_q <= cout_w;
  end

  assign res_row_o = res_w;
  assign carry_o   = carry_q;
endmodule

// File: rtl/bs_simd_seq.sv
module bs_simd_seq
  import bs_simd_pkg::*;
#(
  parameter int NUM_ROWS  = 64,
  parameter int MAX_WIDTH = 16,
  parameter int DEF_WIDTH = 8,
  localparam int RAW = $clog2(NUM_ROWS),
  localparam int WW  = $clog2(MAX_WIDTH + 1),
  localparam int SW  = $clog2(MAX_WIDTH + 2)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_valid_i,
  input  logic [2:0]     cmd_op_i,
  input  logic [RAW-1:0] cmd_src_a_i,
  input  logic [RAW-1:0] cmd_src_b_i,
  input  logic [RAW-1:0] cmd_dst_i,
  input  logic [WW-1:0]  cmd_width_i,
  output logic           busy_o,
  output op_e            op_o,
  output logic [RAW-1:0] row_a_o,
  output logic [RAW-1:0] row_b_o,
  output logic [RAW-1:0] wr_row_o,
  output logic           wr_en_o,
  output logic           tail_o,
  output logic           preset_o,
  output logic           step_o
);
  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_RUN} state_e;

  state_e         state_q;
  op_e            op_q;
  logic [RAW-1:0] a_q, b_q, d_q;
  logic [SW-1:0]  n_q, step_q, w_eff;
  logic           accept, tail, last;

  always_comb begin
    if (cmd_width_i == '0)                 w_eff = SW'(DEF_WIDTH);
    else if (cmd_width_i > WW'(MAX_WIDTH)) w_eff = SW'(MAX_WIDTH);
    else                                   w_eff = SW'(cmd_width_i);
  end

  assign accept = cmd_valid_i && (state_q == S_IDLE) && op_legal(cmd_op_i);
  assign tail   = op_has_tail(op_q) && (step_q == n_q);
  assign last   = op_has_tail(op_q) ? (step_q == n_q) : (step_q == n_q - SW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_AND;
      a_q     <= '0;
      b_q     <= '0;
      d_q     <= '0;
      n_q     <= '0;
      step_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept) begin
          state_q <= S_SETUP;
          op_q    <= op_e'(cmd_op_i);
          a_q     <= cmd_src_a_i;
          b_q     <= cmd_src_b_i;
          d_q     <= cmd_dst_i;
          n_q     <= w_eff;
        end
        S_SETUP: begin
          step_q  <= '0;
          state_q <= S_RUN;
        end
        S_RUN: begin
          if (last) state_q <= S_IDLE;
          else      step_q  <= step_q + SW'(1);
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != S_IDLE);
  assign op_o     = op_q;
  assign row_a_o  = a_q + RAW'(step_q);
  assign row_b_o  = b_q + RAW'(step_q);
  assign wr_en_o  = (state_q == S_RUN) && ((op_q != OP_CMPGT) || tail);
  assign wr_row_o = (op_q == OP_CMPGT) ? d_q : d_q + RAW'(step_q);
  assign tail_o   = tail;
  assign preset_o = (state_q == S_SETUP);
  assign step_o   = (state_q == S_RUN) && !tail;
endmodule

// File: rtl/bs_simd_array.sv
module bs_simd_array
  import bs_simd_pkg::*;
#(
  parameter int NUM_COLS  = 64,
  parameter int NUM_ROWS  = 64,
  parameter int MAX_WIDTH = 16,
  parameter int DEF_WIDTH = 8,
  localparam int RAW = $clog2(NUM_ROWS),
  localparam int WW  = $clog2(MAX_WIDTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [2:0]          cmd_op_i,
  input  logic [RAW-1:0]      cmd_src_a_i,
  input  logic [RAW-1:0]      cmd_src_b_i,
  input  logic [RAW-1:0]      cmd_dst_i,
  input  logic [WW-1:0]       cmd_width_i,
  output logic                busy_o,
  input  logic                wr_en_i,
  input  logic [RAW-1:0]      wr_addr_i,
  input  logic [NUM_COLS-1:0] wr_data_i,
  input  logic [RAW-1:0]      rd_addr_i,
  output logic [NUM_COLS-1:0] rd_data_o
);
  op_e                 op_q;
  logic [RAW-1:0]      row_a, row_b, eng_row, mem_waddr;
  logic                eng_we, tail, preset, step, mem_we;
  logic [NUM_COLS-1:0] a_row, b_row, eng_data, carry_q, mem_wdata;

  bs_simd_seq #(
    .NUM_ROWS(NUM_ROWS), .MAX_WIDTH(MAX_WIDTH), .DEF_WIDTH(DEF_WIDTH)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_src_a_i(cmd_src_a_i), .cmd_src_b_i(cmd_src_b_i), .cmd_dst_i(cmd_dst_i),
    .cmd_width_i(cmd_width_i), .busy_o(busy_o), .op_o(op_q), .row_a_o(row_a),
    .row_b_o(row_b), .wr_row_o(eng_row), .wr_en_o(eng_we), .tail_o(tail),
    .preset_o(preset), .step_o(step)
  );

  bs_simd_lanes #(.NUM_COLS(NUM_COLS)) u_lanes (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_q), .a_row_i(a_row), .b_row_i(b_row),
    .tail_i(tail), .preset_i(preset), .step_i(step), .res_row_o(eng_data),
    .carry_o(carry_q)
  );

  // engine owns the write port for the whole run
  assign mem_we    = eng_we | (wr_en_i & ~busy_o);
  assign mem_waddr = eng_we ? eng_row  : wr_addr_i;
  assign mem_wdata = eng_we ? eng_data : wr_data_i;

  bs_simd_mem #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS)) u_mem (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(mem_we), .waddr_i(mem_waddr),
    .wdata_i(mem_wdata), .raddr_a_i(row_a), .raddr_b_i(row_b), .raddr_h_i(rd_addr_i),
    .rdata_a_o(a_row), .rdata_b_o(b_row), .rdata_h_o(rd_data_o)
  );
endmodule

// File: rtl/bs_simd_array_chk.sv
module bs_simd_array_chk #(
  parameter int NUM_COLS  = 64,
  parameter int MAX_WIDTH = 16,
  parameter int DEF_WIDTH = 8,
  localparam int WW = $clog2(MAX_WIDTH + 1)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cmd_valid_i,
  input logic [2:0]          cmd_op_i,
  input logic [WW-1:0]       cmd_width_i,
  input logic                busy_i,
  input logic                eng_we_i,
  input logic [NUM_COLS-1:0] carry_i,
  input logic [2:0]          op_q_i
);
  function automatic logic [7:0] run_len(logic [2:0] op, logic [WW-1:0] w);
    int n;
    n = (w == '0) ? DEF_WIDTH : ((int'(w) > MAX_WIDTH) ? MAX_WIDTH : int'(w));
    return 8'(1 + n + (((op == 3'd3) || (op == 3'd5)) ? 1 : 0));
  endfunction

  logic [7:0] exp_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q <= '0;
      cnt_q <= '0;
    end else if (cmd_valid_i && !busy_i && (cmd_op_i <= 3'd5)) begin
      exp_q <= run_len(cmd_op_i, cmd_width_i);
      cnt_q <= '0;
    end else if (busy_i) begin
      cnt_q <= cnt_q + 8'd1;
    end
  end

  p_busy_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && (cnt_q == exp_q - 8'd1)) |=> !busy_i);

  p_busy_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && ((cnt_q + 8'd1) < exp_q)) |=> busy_i);

  p_no_accept_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && cmd_valid_i) |=> $stable(op_q_i));

  p_bad_op_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_i && (cmd_op_i > 3'd5)) |=> !busy_i);

  p_eng_write_in_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_we_i |-> busy_i);

  p_carry_preset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |=> ((op_q_i == 3'd4) ? (carry_i == '1) : (carry_i == '0)));
endmodule

bind bs_simd_array bs_simd_array_chk #(
  .NUM_COLS(NUM_COLS), .MAX_WIDTH(MAX_WIDTH), .DEF_WIDTH(DEF_WIDTH)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
  .cmd_width_i(cmd_width_i), .busy_i(busy_o), .eng_we_i(eng_we), .carry_i(carry_q),
  .op_q_i(op_q)
);

// File: tb/bs_simd_array_tb.sv
module bs_simd_array_tb;
  localparam int COLS = 64, ROWS = 64, MAXW = 16, DEFW = 8, RAW = 6, WW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic            cmd_valid = 1'b0;
  logic [2:0]      cmd_op = '0;
  logic [RAW-1:0]  cmd_a = '0, cmd_b = '0, cmd_d = '0;
  logic [WW-1:0]   cmd_w = '0;
  logic            busy;
  logic            wr_en = 1'b0;
  logic [RAW-1:0]  wr_addr = '0, rd_addr = '0;
  logic [COLS-1:0] wr_data = '0, rd_data;

  bs_simd_array u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_src_a_i(cmd_a), .cmd_src_b_i(cmd_b), .cmd_dst_i(cmd_d), .cmd_width_i(cmd_w),
    .busy_o(busy), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  int checks = 0, errors = 0;
  logic [COLS-1:0] mem_m [ROWS];
  int cnt_m;

  task automatic check_eq(string tag, logic [COLS-1:0] got, logic [COLS-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic int eff_w(logic [WW-1:0] w);
    if (w == '0) return DEFW;
    if (int'(w) > MAXW) return MAXW;
    return int'(w);
  endfunction

  function automatic logic [7:0] pat_a(int c); return 8'((c * 37 + 11) % 256); endfunction
  function automatic logic [7:0] pat_b(int c); return 8'((c * 91 + 5) % 256); endfunction

  // kind: 0 and, 1 nor, 2 a, 3 add, 4 sub, 5 gt, 6 b
  function automatic logic [COLS-1:0] exp_row(int kind, int i);
    logic [COLS-1:0] row;
    for (int c = 0; c < COLS; c++) begin
      logic [8:0] a, b, r;
      a = {1'b0, pat_a(c)};
      b = {1'b0, pat_b(c)};
      case (kind)
        0: r = a & b;
        1: r = ~(a | b);
        2: r = a;
        3: r = a + b;
        4: r = a - b;
        5: r = (a > b) ? 9'd1 : 9'd0;
        default: r = b;
      endcase
      row[c] = r[i];
    end
    return row;
  endfunction

  task automatic model_apply(logic [2:0] op, int a, int b, int d, int w);
    logic [32:0] va [COLS];
    logic [32:0] vb [COLS];
    logic [32:0] vr [COLS];
    for (int c = 0; c < COLS; c++) begin
      va[c] = '0;
      vb[c] = '0;
      for (int i = 0; i < w; i++) begin
        va[c][i] = mem_m[(a + i) % ROWS][c];
        vb[c][i] = mem_m[(b + i) % ROWS][c];
      end
      case (op)
        3'd0: vr[c] = va[c] & vb[c];
        3'd1: vr[c] = ~(va[c] | vb[c]);
        3'd2: vr[c] = va[c];
        3'd3: vr[c] = va[c] + vb[c];
        3'd4: vr[c] = va[c] - vb[c];
        default: vr[c] = (va[c] > vb[c]) ? 33'd1 : 33'd0;
      endcase
    end
    if (op == 3'd5) begin
      for (int c = 0; c < COLS; c++) mem_m[d % ROWS][c] = vr[c][0];
    end else begin
      for (int i = 0; i < ((op == 3'd3) ? w + 1 : w); i++)
        for (int c = 0; c < COLS; c++) mem_m[(d + i) % ROWS][c] = vr[c][i];
    end
  endtask

  // behavioural reference of the whole array
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem_m[r] = '0;
      cnt_m = 0;
    end else if (cnt_m > 0) begin
      cnt_m = cnt_m - 1;
    end else begin
      if (wr_en) mem_m[wr_addr] = wr_data;
      if (cmd_valid && cmd_op <= 3'd5) begin
        model_apply(cmd_op, int'(cmd_a), int'(cmd_b), int'(cmd_d), eff_w(cmd_w));
        cnt_m = 1 + eff_w(cmd_w) + (((cmd_op == 3'd3) || (cmd_op == 3'd5)) ? 1 : 0);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check_eq("R7 busy vs model", COLS'(busy), COLS'(cnt_m != 0));
      if (!busy && cnt_m == 0) check_eq("R2 read vs model", rd_data, mem_m[rd_addr]);
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic host_write(int r, logic [COLS-1:0] data);
    wr_en = 1'b1; wr_addr = RAW'(r); wr_data = data;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic load(int base, int kind);
    for (int i = 0; i < 8; i++) host_write(base + i, exp_row(kind, i));
  endtask

  task automatic run(logic [2:0] op, int a, int b, int d, int w, output int len);
    cmd_op = op; cmd_a = RAW'(a); cmd_b = RAW'(b); cmd_d = RAW'(d); cmd_w = WW'(w);
    cmd_valid = 1'b1;
    tick();
    cmd_valid = 1'b0;
    len = 0;
    while (busy) begin
      len++;
      tick();
    end
  endtask

  task automatic check_row(int r, logic [COLS-1:0] exp, string tag);
    rd_addr = RAW'(r);
    #1;
    check_eq(tag, rd_data, exp);
    tick();
  endtask

  initial begin
    int len;
    #12;
    check_eq("R1 busy in reset", COLS'(busy), '0);
    rd_addr = 6'd63;
    #1;
    check_eq("R1 row clear", rd_data, '0);
    #10 rst_n = 1'b1;
    tick();
    check_row(0, '0, "R1 row clear after reset");

    load(0, 2);
    load(8, 6);
    check_row(3, exp_row(2, 3), "R2 host readback");

    run(3'd0, 0, 8, 16, 8, len);
    check_eq("R7 and length", COLS'(len), COLS'(9));
    for (int i = 0; i < 8; i++) check_row(16 + i, exp_row(0, i), "R3 and");
    run(3'd1, 0, 8, 24, 8, len);
    for (int i = 0; i < 8; i++) check_row(24 + i, exp_row(1, i), "R3 nor");
    run(3'd2, 0, 8, 32, 8, len);
    for (int i = 0; i < 8; i++) check_row(32 + i, exp_row(2, i), "R3 copy");

    run(3'd3, 0, 8, 40, 8, len);
    check_eq("R7 add length", COLS'(len), COLS'(10));
    for (int i = 0; i < 9; i++) check_row(40 + i, exp_row(3, i), "R4 add");

    run(3'd4, 0, 8, 16, 8, len);
    check_eq("R7 sub length", COLS'(len), COLS'(9));
    for (int i = 0; i < 8; i++) check_row(16 + i, exp_row(4, i), "R5 sub");

    run(3'd5, 0, 8, 50, 8, len);
    check_eq("R7 cmp length", COLS'(len), COLS'(10));
    check_row(50, exp_row(5, 0), "R6 compare row");
    check_row(51, '0, "R6 single row");

    // R8 and R2: command and host write while busy
    cmd_op = 3'd3; cmd_a = 6'd0; cmd_b = 6'd8; cmd_d = 6'd40; cmd_w = 5'd8;
    cmd_valid = 1'b1;
    tick();
    cmd_op = 3'd2; cmd_a = 6'd0; cmd_d = 6'd58; cmd_w = 5'd2;
    wr_en = 1'b1; wr_addr = 6'd57; wr_data = '1;
    tick();
    cmd_valid = 1'b0; wr_en = 1'b0;
    while (busy) tick();
    check_row(58, '0, "R8 busy cmd dropped");
    check_row(59, '0, "R8 busy cmd dropped");
    check_row(57, '0, "R2 busy write dropped");

    for (int op = 6; op < 8; op++) begin
      cmd_op = 3'(op); cmd_a = 6'd0; cmd_b = 6'd8; cmd_d = 6'd58; cmd_w = 5'd8;
      cmd_valid = 1'b1;
      tick();
      cmd_valid = 1'b0;
      check_eq("R9 illegal op busy", COLS'(busy), '0);
      check_row(58, '0, "R9 illegal op no write");
    end

    run(3'd2, 0, 0, 56, 0, len);
    check_eq("R10 default width length", COLS'(len), COLS'(9));
    for (int i = 0; i < 8; i++) check_row(56 + i, exp_row(2, i), "R10 default width");
    run(3'd2, 0, 0, 24, 20, len);
    check_eq("R10 clamp length", COLS'(len), COLS'(17));
    check_row(33, exp_row(6, 1), "R10 clamp rows");
    check_row(39, exp_row(6, 7), "R10 clamp rows");

    run(3'd2, 8, 0, 60, 8, len);
    check_row(61, exp_row(6, 1), "R11 wrap");
    check_row(2, exp_row(6, 6), "R11 wrap");

    repeat (3) tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule